// File: doc/BRIEF.md
# Quadrature decoder with input conditioning and glitch filter

This block turns the two phase signals of an incremental rotary or linear encoder, plus its once-per-turn index pulse, into single-cycle count-up and count-down pulses and a direction bit. The pulses drive a position counter that sits outside this block. Before decoding, each input can be inverted on its own, the two phases can be exchanged, and phase B can stand in for the index. Each conditioned input then passes through a programmable stability filter that suppresses short glitches.

Two decoding modes are available. Full 4x decoding counts every single-phase transition. Single-phase mode counts only phase A edges and takes the direction from the level of phase B. The decoder reports three events in a sticky status word: index seen, direction changed, and quadrature error (both phases moving in one clock). The status word is cleared when it is read. A mask, managed through separate set and clear strobes, selects which events drive the interrupt line. The inputs are taken to be synchronous to `clk`.

Top module: `quad_decoder`

## Requirements
- R1: `inv_a_i`, `inv_b_i` and `inv_idx_i` each invert their raw input before all other processing. Inverting phase A reverses the counting direction of a forward sequence. With the index inverted, a falling raw index edge raises the index event.
- R2: `swap_ab_i` exchanges the conditioned phases before decoding, so a raw sequence with A leading produces down pulses.
- R3: With `idx_from_b_i` high, the index event comes from rising edges of conditioned phase B, and the raw index input is ignored.
- R4: In full decoding (`edge_a_only_i`=0), every transition in which exactly one filtered phase changes gives exactly one pulse. The pulse is on `cnt_up_o` when the new A XOR the previous B is 1 (A leads: 00→10→11→01→00, written {A,B}), and on `cnt_dn_o` otherwise. With the filter off, the pulse appears two clock edges after the input change and lasts one cycle. Up and down are never both high.
- R5: With `edge_a_only_i`=1, only phase A edges count: up when the new A XOR the current B is 1, down otherwise. Phase B edges alone give no pulse.
- R6: A clock in which both filtered phases change gives no count pulse and sets status bit 2 (quadrature error).
- R7: With `filt_en_i`=1, a filtered input takes a new raw value only after the raw value has been present on `filt_max_i`+1 consecutive clock edges. A shorter excursion is dropped. With the filter off, the filter adds one register stage.
- R8: Status bit 8 holds the direction of the last count (0 up, 1 down; 0 after reset). Status bit 1 is set when a count goes in the direction opposite to that bit.
- R9: Status bit 0 is set by a rising edge of the filtered index source.
- R10: Status bits 2..0 are sticky. A clock with `stat_rd_i` high clears them. An event arriving in the same clock as the read stays set.
- R11: `irq_en_i` sets and `irq_dis_i` clears mask bits (bit order as in the status word), and clear wins when both are applied to one bit. `irq_o` is high when any status bit 2..0 is set together with its mask bit.
- R12: After reset, the count pulses, `irq_o`, the mask and the whole status word are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pha_i | input | 1 | Raw phase A |
| phb_i | input | 1 | Raw phase B |
| idx_i | input | 1 | Raw index |
| inv_a_i | input | 1 | Invert phase A |
| inv_b_i | input | 1 | Invert phase B |
| inv_idx_i | input | 1 | Invert index |
| swap_ab_i | input | 1 | Exchange phases A and B |
| idx_from_b_i | input | 1 | Use conditioned phase B as index source |
| edge_a_only_i | input | 1 | Count phase A edges only |
| filt_en_i | input | 1 | Enable glitch filter |
| filt_max_i | input | FILT_W | Filter hold length minus one |
| stat_rd_i | input | 1 | Status read strobe (clears events) |
| irq_en_i | input | 3 | Write-1 mask set |
| irq_dis_i | input | 3 | Write-1 mask clear |
| stat_o | output | 9 | Status: bit 0 index, bit 1 direction change, bit 2 quadrature error, bit 8 direction |
| irq_mask_o | output | 3 | Current interrupt mask |
| irq_o | output | 1 | Interrupt request |
| cnt_up_o | output | 1 | Count-up pulse |
| cnt_dn_o | output | 1 | Count-down pulse |

## Verification
Two pairs of functions can fall in one clock here. The first pair is a status read and a new event. The bench times an index edge so that its registered event reaches the status register on the same edge at which `stat_rd_i` is high, while an older quadrature-error flag is pending. It then expects the index bit to survive and the old flag to be gone. The second pair is a mask set and a mask clear on the same bit in one cycle, where the clear must win and the interrupt line must fall.

// File: rtl/qd_pkg.sv
package qd_pkg;
  localparam int NUM_IN       = 3;
  localparam int CH_A         = 0;
  localparam int CH_B         = 1;
  localparam int CH_IDX       = 2;
  localparam int NUM_EV       = 3;
  localparam int EV_IDX       = 0;
  localparam int EV_DIRCHG    = 1;
  localparam int EV_QERR      = 2;
  localparam int STAT_DIR_BIT = 8;
  localparam int STAT_W       = STAT_DIR_BIT + 1;
endpackage

// File: rtl/qd_cond.sv
module qd_cond
  import qd_pkg::*;
(
  input  logic              pha_i,
  input  logic              phb_i,
  input  logic              idx_i,
  input  logic              inv_a_i,
  input  logic              inv_b_i,
  input  logic              inv_idx_i,
  input  logic              swap_ab_i,
  input  logic              idx_from_b_i,
  output logic [NUM_IN-1:0] cond_o
);
  logic a_pol, b_pol, i_pol;
  logic a_sw, b_sw;

  always_comb begin
    a_pol = pha_i ^ inv_a_i;
    b_pol = phb_i ^ inv_b_i;
    i_pol = idx_i ^ inv_idx_i;
    a_sw  = swap_ab_i ? b_pol : a_pol;
    b_sw  = swap_ab_i ? a_pol : b_pol;
    cond_o         = '0;
    cond_o[CH_A]   = a_sw;
    cond_o[CH_B]   = b_sw;
    cond_o[CH_IDX] = idx_from_b_i ? b_sw : i_pol;
  end
endmodule

// File: rtl/qd_filter.sv
module qd_filter #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [CW-1:0] limit_i,
  input  logic          din_i,
  output logic          dout_o
);
  logic [CW-1:0] cnt_q, cnt_n;
  logic          out_q, out_n;

  always_comb begin
    cnt_n = cnt_q;
    out_n = out_q;
    if (!en_i) begin
      cnt_n = '0;
      out_n = din_i;
    end else if (din_i == out_q) begin
      cnt_n = '0;
    end else if (cnt_q >= limit_i) begin
      cnt_n = '0;
      out_n = din_i;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      out_q <= out_n;
    end
  end

  assign dout_o = out_q;
endmodule

// File: rtl/qd_core.sv
module qd_core
  import qd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] filt_i,
  input  logic              edge_a_only_i,
  output logic              up_o,
  output logic              dn_o,
  output logic              dir_o,
  output logic [NUM_EV-1:0] ev_o
);
  logic [NUM_IN-1:0] prev_q;
  logic              up_q, dn_q, dir_q;
  logic [NUM_EV-1:0] ev_q;

  logic              a_chg, b_chg, both_chg, cnt_evt, fwd;
  logic              up_n, dn_n, dir_n;
  logic [NUM_EV-1:0] ev_n;

  always_comb begin
    a_chg    = filt_i[CH_A] ^ prev_q[CH_A];
    b_chg    = filt_i[CH_B] ^ prev_q[CH_B];
    both_chg = a_chg & b_chg;
    if (edge_a_only_i) begin
      cnt_evt = a_chg & ~b_chg;
      fwd     = filt_i[CH_A] ^ filt_i[CH_B];
    end else begin
      cnt_evt = a_chg ^ b_chg;
      fwd     = filt_i[CH_A] ^ prev_q[CH_B];
    end
    up_n  = cnt_evt & fwd;
    dn_n  = cnt_evt & ~fwd;
    dir_n = cnt_evt ? ~fwd : dir_q;
    ev_n            = '0;
    ev_n[EV_IDX]    = filt_i[CH_IDX] & ~prev_q[CH_IDX];
    ev_n[EV_DIRCHG] = cnt_evt & (~fwd != dir_q);
    ev_n[EV_QERR]   = both_chg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      up_q   <= 1'b0;
      dn_q   <= 1'b0;
      dir_q  <= 1'b0;
      ev_q   <= '0;
    end else begin
      prev_q <= filt_i;
      up_q   <= up_n;
      dn_q   <= dn_n;
      dir_q  <= dir_n;
      ev_q   <= ev_n;
    end
  end

  assign up_o  = up_q;
  assign dn_o  = dn_q;
  assign dir_o = dir_q;
  assign ev_o  = ev_q;
endmodule

// File: rtl/qd_events.sv
module qd_events
  import qd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev_i,
  input  logic              dir_i,
  input  logic              rd_i,
  input  logic [NUM_EV-1:0] en_set_i,
  input  logic [NUM_EV-1:0] en_clr_i,
  output logic [STAT_W-1:0] stat_o,
  output logic [NUM_EV-1:0] mask_o,
  output logic              irq_o
);
  logic [NUM_EV-1:0] flags_q, flags_n;
  logic [NUM_EV-1:0] mask_q, mask_n;

  always_comb begin
    flags_n = (rd_i ? '0 : flags_q) | ev_i;
    mask_n  = (mask_q | en_set_i) & ~en_clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      mask_q  <= '0;
    end else begin
      flags_q <= flags_n;
      mask_q  <= mask_n;
    end
  end

  always_comb begin
    stat_o               = '0;
    stat_o[NUM_EV-1:0]   = flags_q;
    stat_o[STAT_DIR_BIT] = dir_i;
  end

  assign mask_o = mask_q;
  assign irq_o  = |(flags_q & mask_q);
endmodule

// File: rtl/quad_decoder.sv
module quad_decoder
  import qd_pkg::*;
#(
  parameter int FILT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pha_i,
  input  logic              phb_i,
  input  logic              idx_i,
  input  logic              inv_a_i,
  input  logic              inv_b_i,
  input  logic              inv_idx_i,
  input  logic              swap_ab_i,
  input  logic              idx_from_b_i,
  input  logic              edge_a_only_i,
  input  logic              filt_en_i,
  input  logic [FILT_W-1:0] filt_max_i,
  input  logic              stat_rd_i,
  input  logic [NUM_EV-1:0] irq_en_i,
  input  logic [NUM_EV-1:0] irq_dis_i,
  output logic [STAT_W-1:0] stat_o,
  output logic [NUM_EV-1:0] irq_mask_o,
  output logic              irq_o,
  output logic              cnt_up_o,
  output logic              cnt_dn_o
);
  logic [1:0]        rst_sync_q;
  logic              srst_n;
  logic [NUM_IN-1:0] cond_w;
  logic [NUM_IN-1:0] filt_w;
  logic [NUM_EV-1:0] core_ev;
  logic              core_dir;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  qd_cond u_cond (
    .pha_i        (pha_i),
    .phb_i        (phb_i),
    .idx_i        (idx_i),
    .inv_a_i      (inv_a_i),
    .inv_b_i      (inv_b_i),
    .inv_idx_i    (inv_idx_i),
    .swap_ab_i    (swap_ab_i),
    .idx_from_b_i (idx_from_b_i),
    .cond_o       (cond_w)
  );

  for (genvar g = 0; g < NUM_IN; g++) begin : g_filt
    qd_filter #(.CW(FILT_W)) u_filt (
      .clk     (clk),
      .rst_n   (srst_n),
      .en_i    (filt_en_i),
      .limit_i (filt_max_i),
      .din_i   (cond_w[g]),
      .dout_o  (filt_w[g])
    );
  end

  qd_core u_core (
    .clk           (clk),
    .rst_n         (srst_n),
    .filt_i        (filt_w),
    .edge_a_only_i (edge_a_only_i),
    .up_o          (cnt_up_o),
    .dn_o          (cnt_dn_o),
    .dir_o         (core_dir),
    .ev_o          (core_ev)
  );

  qd_events u_ev (
    .clk      (clk),
    .rst_n    (srst_n),
    .ev_i     (core_ev),
    .dir_i    (core_dir),
    .rd_i     (stat_rd_i),
    .en_set_i (irq_en_i),
    .en_clr_i (irq_dis_i),
    .stat_o   (stat_o),
    .mask_o   (irq_mask_o),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/qd_chk.sv
module qd_chk
  import qd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              up,
  input logic              dn,
  input logic [NUM_EV-1:0] ev,
  input logic              rd,
  input logic [NUM_EV-1:0] flags,
  input logic [NUM_EV-1:0] mask,
  input logic [NUM_EV-1:0] en_clr,
  input logic              irq
);
  // R4
  excl_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(up && dn));

  // R6
  qerr_nocount_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev[EV_QERR] |-> (!up && !dn));

  // R10
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && ev == '0) |=> (flags == '0));

  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> (($past(flags) & ~flags) == '0));

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((flags & mask) != '0));

  // R11
  dis_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr != '0) |=> ((mask & $past(en_clr)) == '0));
endmodule

bind quad_decoder qd_chk u_chk (
  .clk    (clk),
  .rst_n  (srst_n),
  .up     (cnt_up_o),
  .dn     (cnt_dn_o),
  .ev     (core_ev),
  .rd     (stat_rd_i),
  .flags  (stat_o[2:0]),
  .mask   (irq_mask_o),
  .en_clr (irq_dis_i),
  .irq    (irq_o)
);

// File: tb/sim_quad_decoder.sv
module sim_quad_decoder;
  localparam int PERIOD = 10;

  logic       clk, rst_n;
  logic       pha, phb, idx;
  logic       inv_a, inv_b, inv_idx, swap_ab, idx_from_b, edge_a_only, filt_en;
  logic [5:0] filt_max;
  logic       stat_rd;
  logic [2:0] irq_en, irq_dis;
  logic [8:0] stat;
  logic [2:0] mask;
  logic       irq, up, dn;

  int checks = 0;
  int errors = 0;
  int up_seen = 0;
  int dn_seen = 0;
  int base_up, base_dn;

  // {a, b, expected up, expected down, expected direction}
  localparam logic [4:0] VEC [9] = '{
    5'b10100, 5'b11100, 5'b01100, 5'b00100,
    5'b01011, 5'b11011, 5'b10011, 5'b00011,
    5'b10100
  };

  quad_decoder u0 (
    .clk(clk), .rst_n(rst_n), .pha_i(pha), .phb_i(phb), .idx_i(idx),
    .inv_a_i(inv_a), .inv_b_i(inv_b), .inv_idx_i(inv_idx), .swap_ab_i(swap_ab),
    .idx_from_b_i(idx_from_b), .edge_a_only_i(edge_a_only), .filt_en_i(filt_en),
    .filt_max_i(filt_max), .stat_rd_i(stat_rd), .irq_en_i(irq_en),
    .irq_dis_i(irq_dis), .stat_o(stat), .irq_mask_o(mask), .irq_o(irq),
    .cnt_up_o(up), .cnt_dn_o(dn)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (up) up_seen++;
      if (dn) dn_seen++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive phases, return just after the second edge (pulse visible)
  task automatic step(input logic a, input logic b);
    @(negedge clk);
    pha = a;
    phb = b;
    settle(2);
  endtask

  task automatic clear_status();
    @(negedge clk) stat_rd = 1'b1;
    @(negedge clk) stat_rd = 1'b0;
  endtask

  task automatic mark();
    base_up = up_seen;
    base_dn = dn_seen;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    pha = 0; phb = 0; idx = 0;
    inv_a = 0; inv_b = 0; inv_idx = 0; swap_ab = 0; idx_from_b = 0;
    edge_a_only = 0; filt_en = 0; filt_max = 6'd0;
    stat_rd = 0; irq_en = '0; irq_dis = '0;
    settle(3);
    rst_n = 1'b1;
    settle(4);

    // R12 reset state
    chk("R12 up", int'(up), 0);
    chk("R12 dn", int'(dn), 0);
    chk("R12 irq", int'(irq), 0);
    chk("R12 mask", int'(mask), 0);
    chk("R12 stat", int'(stat), 0);

    // R4 / R8 table walk
    for (int i = 0; i < 9; i++) begin
      step(VEC[i][4], VEC[i][3]);
      chk($sformatf("R4 up step %0d", i), int'(up), int'(VEC[i][2]));
      chk($sformatf("R4 dn step %0d", i), int'(dn), int'(VEC[i][1]));
      chk($sformatf("R8 dir step %0d", i), int'(stat[8]), int'(VEC[i][0]));
    end
    @(negedge clk);
    chk("R8 dirchg flag", int'(stat[1]), 1);
    chk("R6 no qerr yet", int'(stat[2]), 0);
    step(0, 0);
    settle(2);
    clear_status();
    chk("R10 cleared", int'(stat[2:0]), 0);

    // R6 both phases at once
    step(1, 1);
    chk("R6 no up", int'(up), 0);
    chk("R6 no dn", int'(dn), 0);
    @(negedge clk);
    chk("R6 qerr flag", int'(stat[2]), 1);

    // R10 read collides with index event; old qerr must clear
    @(negedge clk) idx = 1'b1;
    settle(2);
    stat_rd = 1'b1;
    @(negedge clk) stat_rd = 1'b0;
    chk("R10 idx survives read", int'(stat[0]), 1);
    chk("R10 old qerr cleared", int'(stat[2]), 0);
    step(0, 1);
    step(0, 0);
    idx = 1'b0;
    settle(3);
    clear_status();

    // R9 / R11 index event and mask
    @(negedge clk) idx = 1'b1;
    settle(3);
    chk("R9 idx flag", int'(stat[0]), 1);
    chk("R11 masked irq", int'(irq), 0);
    @(negedge clk) irq_en = 3'b001;
    @(negedge clk) irq_en = 3'b000;
    chk("R11 mask set", int'(mask), 1);
    chk("R11 irq on", int'(irq), 1);
    irq_en = 3'b001; irq_dis = 3'b001;
    @(negedge clk) begin irq_en = '0; irq_dis = '0; end
    chk("R11 clear wins", int'(mask), 0);
    chk("R11 irq off", int'(irq), 0);
    @(negedge clk) irq_en = 3'b010;
    @(negedge clk) irq_en = 3'b000;
    chk("R11 other bit no irq", int'(irq), 0);
    @(negedge clk) irq_dis = 3'b111;
    @(negedge clk) irq_dis = 3'b000;
    idx = 1'b0;
    settle(3);
    clear_status();

    // R7 filter
    filt_en = 1'b1; filt_max = 6'd3;
    settle(4);
    mark();
    @(negedge clk) pha = 1'b1;
    settle(3);
    pha = 1'b0;
    settle(8);
    chk("R7 glitch up", up_seen - base_up, 0);
    chk("R7 glitch dn", dn_seen - base_dn, 0);
    @(negedge clk) pha = 1'b1;
    settle(4);
    chk("R7 not yet", int'(up), 0);
    @(negedge clk);
    chk("R7 accepted", int'(up), 1);
    pha = 1'b0;
    settle(8);
    filt_en = 1'b0; filt_max = 6'd0;
    settle(4);
    clear_status();

    // R5 phase-A-only counting
    edge_a_only = 1'b1;
    settle(2);
    step(1, 0);
    chk("R5 A rise B low up", int'(up), 1);
    step(1, 1);
    chk("R5 B edge no up", int'(up), 0);
    chk("R5 B edge no dn", int'(dn), 0);
    step(0, 1);
    chk("R5 A fall B high up", int'(up), 1);
    step(1, 1);
    chk("R5 A rise B high dn", int'(dn), 1);
    step(1, 0);
    step(0, 0);
    edge_a_only = 1'b0;
    settle(4);

    // R1 inverted phase A reverses direction
    inv_a = 1'b1;
    settle(4);
    mark();
    step(1, 0); step(1, 1); step(0, 1); step(0, 0);
    settle(2);
    chk("R1 inv_a dn", dn_seen - base_dn, 4);
    chk("R1 inv_a up", up_seen - base_up, 0);
    inv_a = 1'b0;
    settle(4);

    // R2 swap reverses direction
    swap_ab = 1'b1;
    settle(4);
    mark();
    step(1, 0); step(1, 1); step(0, 1); step(0, 0);
    settle(2);
    chk("R2 swap dn", dn_seen - base_dn, 4);
    chk("R2 swap up", up_seen - base_up, 0);
    swap_ab = 1'b0;
    settle(4);

    // R1 inverted index
    inv_idx = 1'b1;
    settle(4);
    clear_status();
    @(negedge clk) idx = 1'b1;
    settle(4);
    chk("R1 inv idx raw rise", int'(stat[0]), 0);
    @(negedge clk) idx = 1'b0;
    settle(4);
    chk("R1 inv idx raw fall", int'(stat[0]), 1);
    inv_idx = 1'b0;
    settle(4);
    clear_status();

    // R3 index taken from phase B
    idx_from_b = 1'b1;
    settle(4);
    clear_status();
    @(negedge clk) idx = 1'b1;
    settle(4);
    chk("R3 raw idx ignored", int'(stat[0]), 0);
    @(negedge clk) phb = 1'b1;
    settle(4);
    chk("R3 idx from B", int'(stat[0]), 1);
    idx_from_b = 1'b0;
    idx = 1'b0;
    settle(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule